// File: doc/BRIEF.md
# DMA Peripheral Request/Acknowledge Handshake Arbiter

This block controls hardware flow control between a set of DMA channels and up to sixteen peripheral request lines. Each channel carries a small configuration word that can bind the channel's source side to one request line and its destination side to another. Each side has its own enable bit. A started channel may be given a burst only when every request line it has enabled is high. Only one channel holds the burst permit at a time. The permit goes to the lowest-numbered channel that is eligible.

The datapath that moves the data reports two strobes for the granted burst: one when the read phase completes and one when the write phase completes. On the read strobe the block raises the acknowledge of the source-side line. On the write strobe it raises the acknowledge of the destination-side line, and the burst permit is released. An acknowledge stays high until the peripheral drops its request. Request inputs are asynchronous and pass through a two-flop synchronizer before any use.

Top module: `dma_hs_arbiter`

## Requirements
- R1: While reset is low and on the first cycle after it, `grant_o` and `ack_o` are all zero and the request synchronizer holds zeros.
- R2: Channel c owns bits `c*14 +: 14` of `chan_cfg_i`. Within that word, bits 6:3 select the source line and bit 7 enables it, and bits 12:9 select the destination line and bit 13 enables it. A started channel with neither side enabled is granted on the first clock edge, without any request.
- R3: At most one bit of `grant_o` is high. Among the eligible started channels, the lowest index wins.
- R4: A channel with any enabled bound request line low is not granted. After `req_i` rises, the grant appears on the third clock edge: two synchronizer flops plus the grant register.
- R5: A grant is held until `wr_done_i`. The edge that samples `wr_done_i` clears it, and a channel that is still eligible is granted again on the following edge.
- R6: `rd_done_i` during a grant raises `ack_o` for the source line on the next edge, if source handshake is enabled. No destination acknowledge is raised by it.
- R7: `wr_done_i` during a grant raises `ack_o` for the destination line on the next edge, if destination handshake is enabled.
- R8: An acknowledge bit stays high for two edges after its `req_i` falls and is low after the third edge.
- R9: `rd_done_i` and `wr_done_i` have no effect while no channel is granted.
- R10: A channel whose `chan_start_i` bit is low is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NLINES | Asynchronous peripheral request lines |
| chan_start_i | input | NCH | Channel has pending work |
| chan_cfg_i | input | NCH*14 | Packed per-channel handshake configuration |
| rd_done_i | input | 1 | Read phase of the granted burst completed |
| wr_done_i | input | 1 | Write phase of the granted burst completed |
| grant_o | output | NCH | One-hot burst permit |
| ack_o | output | NLINES | Peripheral acknowledge lines |

## Verification
The hardest case to reach from the ports is a scan that is blocked by a low-numbered channel and then freed later. In that case a request rises while a higher channel holds the burst, and the blocked low channel must win the next scan rather than run in index order. The bench reaches it in three steps. It starts three channels, with the lowest one bound to a line that is low. It raises that line while the middle channel's successor holds the grant. It then releases the burst only after the synchronizer latency has passed. The acknowledge drop is timed edge by edge against the two-flop delay.

// File: rtl/dma_hs_arbiter.sv
`timescale 1ns/1ps
module dma_hs_arbiter #(
  parameter int NCH    = 8,
  parameter int NLINES = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NLINES-1:0]              req_i,
  input  logic [NCH-1:0]                 chan_start_i,
  input  logic [NCH*(2*$clog2(NLINES)+6)-1:0] chan_cfg_i,
  input  logic                           rd_done_i,
  input  logic                           wr_done_i,
  output logic [NCH-1:0]                 grant_o,
  output logic [NLINES-1:0]              ack_o
);
  localparam int LW      = $clog2(NLINES);
  localparam int CW      = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SRC_LSB = 3;
  localparam int SRC_EN  = SRC_LSB + LW;
  localparam int DST_LSB = SRC_EN + 2;
  localparam int DST_EN  = DST_LSB + LW;
  localparam int CFGW    = DST_EN + 1;

  logic [NLINES-1:0] req_m, req_s, ack_q, ack_set;
  logic [NCH-1:0]    elig, pick, grant_q;
  logic [CW-1:0]     gidx;
  logic [CFGW-1:0]   gcf;
  logic              busy;
  logic              unused_cfg;

  assign unused_cfg = ^chan_cfg_i;
  assign busy    = |grant_q;
  assign pick    = elig & (~elig + NCH'(1));
  assign grant_o = grant_q;
  assign ack_o   = ack_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CFGW-1:0] cf;
    assign cf = chan_cfg_i[c*CFGW +: CFGW];
    assign elig[c] = chan_start_i[c]
                   & (~cf[SRC_EN] | req_s[cf[SRC_LSB +: LW]])
                   & (~cf[DST_EN] | req_s[cf[DST_LSB +: LW]]);

    // R4 / R10: a new grant only on enabled lines that were high
    a_r4_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_q[c]) |-> $past(chan_start_i[c]
        && (!cf[SRC_EN] || req_s[cf[SRC_LSB +: LW]])
        && (!cf[DST_EN] || req_s[cf[DST_LSB +: LW]])));
  end

  always_comb begin
    gidx = '0;
    for (int c = 0; c < NCH; c++)
      if (grant_q[c]) gidx = CW'(c);
  end

  assign gcf = chan_cfg_i[gidx*CFGW +: CFGW];

  always_comb begin
    ack_set = '0;
    if (busy && rd_done_i && gcf[SRC_EN]) ack_set[gcf[SRC_LSB +: LW]] = 1'b1;
    if (busy && wr_done_i && gcf[DST_EN]) ack_set[gcf[DST_LSB +: LW]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_m   <= '0;
      req_s   <= '0;
      ack_q   <= '0;
      grant_q <= '0;
    end else begin
      req_m <= req_i;
      req_s <= req_m;
      ack_q <= (ack_q | ack_set) & req_s;
      if (busy) begin
        if (wr_done_i) grant_q <= '0;
      end else begin
        grant_q <= pick;
      end
    end
  end

  a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !wr_done_i |=> $stable(grant_q));

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_done_i |=> grant_q == '0);

  a_r6_src_ack: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_done_i && gcf[SRC_EN] && req_s[gcf[SRC_LSB +: LW]]
      |=> ack_q[$past(gcf[SRC_LSB +: LW])]);

  a_r7_dst_ack: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_done_i && gcf[DST_EN] && req_s[gcf[DST_LSB +: LW]]
      |=> ack_q[$past(gcf[DST_LSB +: LW])]);

  a_r8_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done_i || wr_done_i || (|ack_q) |=> (ack_q & ~$past(req_s)) == '0);

  a_r9_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && ack_q == '0 |=> ack_q == '0);
endmodule

// File: tb/sim_dma_hs_arbiter.sv
`timescale 1ns/1ps
module sim_dma_hs_arbiter;
  localparam int NCH = 8, NL = 16, CFGW = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NL-1:0] req_i = '0;
  logic [NCH-1:0] start = '0;
  logic [NCH*CFGW-1:0] cfg = '0;
  logic rd_done = 1'b0, wr_done = 1'b0;
  logic [NCH-1:0] grant;
  logic [NL-1:0] ack;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_hs_arbiter #(.NCH(NCH), .NLINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .chan_start_i(start),
    .chan_cfg_i(cfg), .rd_done_i(rd_done), .wr_done_i(wr_done),
    .grant_o(grant), .ack_o(ack));

  function automatic logic [CFGW-1:0] mk(input bit se, input int sl, input bit de, input int dl);
    logic [CFGW-1:0] v = '0;
    v[6:3] = sl[3:0]; v[7] = se; v[12:9] = dl[3:0]; v[13] = de;
    return v;
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_i = '0; start = '0; cfg = '0; rd_done = 0; wr_done = 0;
    step(2);
    rst_n = 1;
  endtask

  task automatic pulse_wr();
    wr_done = 1; step(1); wr_done = 0;
  endtask

  task automatic t_reset();
    do_reset();
    req_i = '1;
    chk("R1 grant after reset", 32'(grant), 0);
    chk("R1 ack after reset", 32'(ack), 0);
  endtask

  task automatic t_plain();
    do_reset();
    step(2);
    chk("R10 unstarted channel", 32'(grant), 0);
    start[2] = 1;
    step(1);
    chk("R2 no-handshake grant", 32'(grant), 32'h04);
    pulse_wr();
    chk("R5 release on write done", 32'(grant), 0);
    step(1);
    chk("R5 regrant", 32'(grant), 32'h04);
    start[2] = 0;
    pulse_wr();
    step(2);
    chk("R10 stopped channel idle", 32'(grant), 0);
  endtask

  task automatic t_src_wait();
    do_reset();
    cfg[1*CFGW +: CFGW] = mk(1, 5, 0, 0);
    start[1] = 1;
    step(3);
    chk("R4 blocked while low", 32'(grant), 0);
    req_i[5] = 1;
    step(2);
    chk("R4 synchronizer latency", 32'(grant), 0);
    step(1);
    chk("R4 grant third edge", 32'(grant), 32'h02);
  endtask

  task automatic t_acks();
    do_reset();
    cfg[1*CFGW +: CFGW] = mk(1, 5, 1, 12);
    req_i[5] = 1; req_i[12] = 1;
    start[1] = 1;
    step(3);
    chk("R2 both sides grant", 32'(grant), 32'h02);
    rd_done = 1; step(1); rd_done = 0;
    chk("R6 source ack only", 32'(ack), 32'h0020);
    start[1] = 0;
    pulse_wr();
    chk("R7 destination ack", 32'(ack), 32'h1020);
    req_i[5] = 0;
    step(2);
    chk("R8 ack held two edges", 32'(ack), 32'h1020);
    step(1);
    chk("R8 ack dropped", 32'(ack), 32'h1000);
  endtask

  task automatic t_priority();
    do_reset();
    cfg[0 +: CFGW] = mk(1, 2, 0, 0);
    start[0] = 1; start[3] = 1; start[6] = 1;
    step(1);
    chk("R3 lowest eligible wins", 32'(grant), 32'h08);
    start[3] = 0;
    pulse_wr();
    chk("R3 released", 32'(grant), 0);
    step(1);
    chk("R3 next channel", 32'(grant), 32'h40);
    req_i[2] = 1;
    step(3);
    chk("R5 hold while request rises", 32'(grant), 32'h40);
    start[6] = 0;
    pulse_wr();
    step(1);
    chk("R3 freed low channel wins", 32'(grant), 32'h01);
  endtask

  task automatic t_idle_done();
    do_reset();
    cfg[0 +: CFGW] = mk(1, 4, 1, 7);
    req_i[4] = 1; req_i[7] = 1;
    step(3);
    rd_done = 1; wr_done = 1; step(1); rd_done = 0; wr_done = 0;
    chk("R9 ack unchanged", 32'(ack), 0);
    chk("R9 no grant", 32'(grant), 0);
  endtask

  task automatic t_dst_gate();
    do_reset();
    cfg[4*CFGW +: CFGW] = mk(0, 0, 1, 9);
    start[4] = 1;
    step(4);
    chk("R2 destination line gates", 32'(grant), 0);
    req_i[9] = 1;
    step(3);
    chk("R2 destination line grant", 32'(grant), 32'h10);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_src_wait();
    t_acks();
    t_priority();
    t_idle_done();
    t_dst_gate();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule